// File: doc/BRIEF.md
# Hashed-Index Two-Way Tag Directory

This block holds the tags of a two-way set-associative second-level cache of 128 KiB with 64-byte lines, so it has 1024 sets and a 10-bit set index. Every lookup carries a physical byte address. The block drops the six line-offset bits to form the block number, then derives the set from that number. A mode input chooses how the set is derived: plain low-bit selection, remainder modulo the prime 1021, or an XOR fold of two 10-bit slices. Each lookup returns hit or miss and a way. On a miss the block allocates a line at once, filling an empty way first and the least recently used way otherwise.

The set index is hashed, so each entry stores the whole block number as its tag. The same stored value removes lines during a page flush. A flush names a 4 KiB physical page. The block then walks the 64 block numbers of that page, one per cycle. For each block it recomputes the hashed set and clears any way that holds that block. While the walk runs the busy flag is high and no lookups are accepted. Changing the mode wipes the directory.

Top module: `hashdir_tag_dir`

## Requirements
- R1: With mode 0 (base), the set is block-number bits [9:0], where the block number is address bits [31:6]. A first access to a block misses and a repeat access hits in the same way.
- R2: An accepted lookup gives resp_valid with its hit and way in the very next cycle and at no other time. Lookups may be accepted in consecutive cycles, and each one sees the allocation made by the one before it.
- R3: With mode 2 (XOR), the set is block-number bits [9:0] XOR bits [19:10].
- R4: With mode 1 (prime), the set is the block number modulo 1021, so sets 1021 to 1023 are never used. Mode 3 behaves as mode 0.
- R5: The tag is the full block number. Different blocks that share a set never hit on each other's entry.
- R6: A miss fills way 0 if it is empty, else way 1 if it is empty, else the least recently used way. Every hit and every fill makes the accessed way the most recently used.
- R7: A flush of page P takes exactly 64 busy cycles. During those cycles req_ready is low. Afterwards every block of P misses and blocks of other pages still hit, in any mode.
- R8: A change of hash_mode empties the directory. req_ready is low in the cycle where the change is seen.
- R9: After reset the directory is empty, resp_valid and flush_busy are low, and req_ready is high.
- R10: On a miss, resp_way gives the way just allocated. On a hit, it gives the way that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_mode | input | 2 | Set-index function: 0 base, 1 prime, 2 XOR, 3 base |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Physical byte address of the lookup |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Result was a hit |
| resp_way | output | 1 | Way that hit or was allocated |
| flush_valid | input | 1 | Page flush command present |
| flush_page | input | 20 | Physical page number to flush (address bits [31:12]) |
| flush_busy | output | 1 | Page walk in progress |

## Verification
The hardest case to reach is forcing three different blocks into one hashed set. Only then do eviction and LRU order become visible at the hit/miss port. For XOR and prime modes the stimulus computes three block numbers that collide under the chosen hash but fall in different sets under plain selection. These include a prime-mode block with a large high part, which exercises several folding stages. The expected evictions are then checked one miss at a time. The flush scenario fills lines at the start, middle and end of one page, plus a line of the next page. It then checks which of them survive the walk.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
   typedef enum logic [1:0] {
      HM_BASE  = 2'd0,
      HM_PRIME = 2'd1,
      HM_XOR   = 2'd2,
      HM_ALT   = 2'd3
   } hash_mode_e;
endpackage

// File: rtl/hdir_set_hash.sv
module hdir_set_hash #(
   parameter int BN_W  = 26,
   parameter int SET_W = 10,
   parameter int PRIME = 1021
) (
   input  logic [1:0]       mode,
   input  logic [BN_W-1:0]  bn,
   output logic [SET_W-1:0] set_idx
);
   import hdir_pkg::*;

   localparam int K     = (1 << SET_W) - PRIME;
   localparam int FW    = BN_W + 2;
   localparam int FOLDS = BN_W - SET_W + 2;

   if (BN_W < 2 * SET_W) begin : g_bad_width
      $error("block number too narrow for XOR folding");
   end
   if (PRIME >= (1 << SET_W) || K * 4 > (1 << SET_W)) begin : g_bad_prime
      $error("prime must lie just below the set count");
   end

   logic [SET_W-1:0] base_set, xor_set, mod_set;
   logic [FW-1:0]    acc_v;

   assign base_set = bn[SET_W-1:0];
   assign xor_set  = bn[SET_W-1:0] ^ bn[2*SET_W-1:SET_W];

   // 2^SET_W is congruent to K modulo PRIME: fold the high part down repeatedly
   always_comb begin
      acc_v = FW'(bn);
      for (int i = 0; i < FOLDS; i++) begin
         acc_v = (acc_v >> SET_W) * FW'(K) + FW'(acc_v[SET_W-1:0]);
      end
      if (acc_v >= FW'(PRIME)) acc_v = acc_v - FW'(PRIME);
      mod_set = acc_v[SET_W-1:0];
   end

   always_comb begin
      case (hash_mode_e'(mode))
         HM_PRIME: set_idx = mod_set;
         HM_XOR:   set_idx = xor_set;
         default:  set_idx = base_set;
      endcase
   end
endmodule

// File: rtl/hdir_victim_pick.sv
module hdir_victim_pick (
   input  logic way0_vld,
   input  logic way1_vld,
   input  logic lru_way,
   output logic victim
);
   always_comb begin
      if (!way0_vld)      victim = 1'b0;
      else if (!way1_vld) victim = 1'b1;
      else                victim = lru_way;
   end
endmodule

// File: rtl/hdir_page_walker.sv
module hdir_page_walker #(
   parameter int PPN_W  = 20,
   parameter int WALK_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [PPN_W-1:0]        page,
   output logic                    busy,
   output logic [PPN_W+WALK_W-1:0] walk_bn
);
   localparam logic [WALK_W-1:0] LAST = '1;

   logic [WALK_W-1:0] cnt_q;
   logic [PPN_W-1:0]  page_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         page_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         page_q <= page;
      end else if (busy_q) begin
         if (cnt_q == LAST) busy_q <= 1'b0;
         cnt_q <= cnt_q + WALK_W'(1);
      end
   end

   assign busy    = busy_q;
   assign walk_bn = {page_q, cnt_q};

   // R7: the walk ends only after the last block of the page
   p_walk_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(cnt_q) == LAST);

   // R7: one block per cycle while walking
   p_walk_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(start)) |-> cnt_q == $past(cnt_q) + WALK_W'(1));
endmodule

// File: rtl/hashdir_tag_dir.sv
module hashdir_tag_dir #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 6,
   parameter int SET_W    = 10,
   parameter int PAGE_W   = 12,
   parameter int PRIME    = 1021
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               hash_mode,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   output logic                     req_ready,
   output logic                     resp_valid,
   output logic                     resp_hit,
   output logic                     resp_way,
   input  logic                     flush_valid,
   input  logic [ADDR_W-PAGE_W-1:0] flush_page,
   output logic                     flush_busy
);
   import hdir_pkg::*;

   localparam int BN_W   = ADDR_W - OFFSET_W;
   localparam int SETS   = 1 << SET_W;
   localparam int PPN_W  = ADDR_W - PAGE_W;
   localparam int WALK_W = PAGE_W - OFFSET_W;
   localparam int WAYS   = 2;

   if (PAGE_W <= OFFSET_W) begin : g_bad_page
      $error("page must hold more than one line");
   end

   logic [1:0]       mode_q;
   logic             mode_chg, flush_go, acc;
   logic [BN_W-1:0]  lk_bn, wk_bn;
   logic [SET_W-1:0] lk_set, wk_set;
   logic [WAYS-1:0]  hit_vec, vld_vec, wk_hit;
   logic             any_hit, victim, sel_way;
   logic [SETS-1:0]  lru_q;

   assign mode_chg  = (hash_mode != mode_q);
   assign flush_go  = flush_valid && !flush_busy && !mode_chg;
   assign req_ready = !flush_busy && !mode_chg && !flush_valid;
   assign acc       = req_valid && req_ready;
   assign lk_bn     = req_addr[ADDR_W-1:OFFSET_W];

   hdir_set_hash #(.BN_W(BN_W), .SET_W(SET_W), .PRIME(PRIME)) u_lk_hash (
      .mode(mode_q), .bn(lk_bn), .set_idx(lk_set));

   hdir_page_walker #(.PPN_W(PPN_W), .WALK_W(WALK_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(flush_go), .page(flush_page),
      .busy(flush_busy), .walk_bn(wk_bn));

   hdir_set_hash #(.BN_W(BN_W), .SET_W(SET_W), .PRIME(PRIME)) u_wk_hash (
      .mode(mode_q), .bn(wk_bn), .set_idx(wk_set));

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0] vld_q;
      logic [BN_W-1:0] tag_q [SETS];
      logic            fill;

      assign fill       = acc && !any_hit && (victim == 1'(w));
      assign vld_vec[w] = vld_q[lk_set];
      assign hit_vec[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_bn);
      assign wk_hit[w]  = vld_q[wk_set] && (tag_q[wk_set] == wk_bn);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else if (mode_chg) begin
            vld_q <= '0;
         end else begin
            if (flush_busy && wk_hit[w]) vld_q[wk_set] <= 1'b0;
            if (fill)                    vld_q[lk_set] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (fill) tag_q[lk_set] <= lk_bn;
      end
   end

   assign any_hit = |hit_vec;

   hdir_victim_pick u_pick (
      .way0_vld(vld_vec[0]), .way1_vld(vld_vec[1]),
      .lru_way(lru_q[lk_set]), .victim(victim));

   assign sel_way = any_hit ? hit_vec[1] : victim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= 2'(HM_BASE);
         lru_q      <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_way   <= 1'b0;
      end else begin
         if (mode_chg) mode_q <= hash_mode;
         if (acc) lru_q[lk_set] <= ~sel_way;
         resp_valid <= acc;
         if (acc) begin
            resp_hit <= any_hit;
            resp_way <= sel_way;
         end
      end
   end

   // R7: no lookup accepted during a page walk
   p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |-> !req_ready);

   // R2: a result follows every accepted lookup
   p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> resp_valid);

   // R2: no result without an accepted lookup
   p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !resp_valid);

   // R4: prime hashing never reaches the top sets
   p_prime_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_q == 2'(HM_PRIME)) |-> lk_set < SET_W'(PRIME));

   // R5: full tags keep the two ways of a set distinct
   p_hit_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> $onehot0(hit_vec));

   // R8: the first lookup after a mode change misses
   p_mode_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && $past(mode_chg)) |=> !resp_hit);
endmodule

// File: tb/tb_hashdir_tag_dir.sv
module tb_hashdir_tag_dir;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  hash_mode = 2'd0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, resp_valid, resp_hit, resp_way;
   logic        flush_valid = 1'b0;
   logic [19:0] flush_page = '0;
   logic        flush_busy;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   hashdir_tag_dir dut (
      .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
      .flush_valid(flush_valid), .flush_page(flush_page), .flush_busy(flush_busy));

   function automatic logic [31:0] blk(input longint bn);
      return 32'(bn << 6);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic lookup(input longint bn, input bit exp_hit, input bit exp_way, input string req);
      @(negedge clk);
      check(req_ready == 1'b1, {req, " ready"}, req_ready, 1);
      req_valid = 1'b1;
      req_addr  = blk(bn);
      @(negedge clk);
      req_valid = 1'b0;
      check(resp_valid == 1'b1, {req, " resp_valid"}, resp_valid, 1);
      check(resp_hit == exp_hit, {req, " hit"}, resp_hit, exp_hit);
      check(resp_way == exp_way, {req, " R10 way"}, resp_way, exp_way);
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      hash_mode = m;
      #1;
      check(req_ready == 1'b0, "R8 ready low on mode change", req_ready, 0);
      @(negedge clk);
      check(req_ready == 1'b1, "R8 ready back after change", req_ready, 1);
   endtask

   task automatic t_reset();
      check(resp_valid == 1'b0, "R9 resp_valid", resp_valid, 0);
      check(flush_busy == 1'b0, "R9 flush_busy", flush_busy, 0);
      check(req_ready == 1'b1, "R9 req_ready", req_ready, 1);
   endtask

   task automatic t_base();
      lookup(1, 0, 0, "R9 empty after reset");
      lookup(1, 1, 0, "R1 repeat hit");
      lookup(1025, 0, 1, "R5 same set second way");
      lookup(1, 1, 0, "R5 no alias way0");
      lookup(1025, 1, 1, "R5 no alias way1");
      lookup(1, 1, 0, "R6 touch way0");
      lookup(2049, 0, 1, "R6 evict lru way1");
      lookup(1025, 0, 0, "R6 evicted block refills way0");
      lookup(2049, 1, 1, "R6 survivor hits");
   endtask

   task automatic t_b2b();
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = blk(7);
      @(negedge clk);
      check(resp_valid && !resp_hit && resp_way == 0, "R2 b2b first miss", resp_hit, 0);
      req_addr = blk(7);
      @(negedge clk);
      check(resp_valid && resp_hit && resp_way == 0, "R2 b2b sees fill", resp_hit, 1);
      req_addr = blk(8);
      @(negedge clk);
      check(resp_valid && !resp_hit, "R2 b2b third", resp_hit, 0);
      req_valid = 1'b0;
      @(negedge clk);
      check(resp_valid == 1'b0, "R2 no result without request", resp_valid, 0);
   endtask

   task automatic t_xor();
      set_mode(2'd2);
      lookup(2049, 0, 0, "R8 wiped by mode change");
      lookup(1, 0, 0, "R3 A fill");
      lookup(1024, 0, 1, "R3 B same xor set");
      lookup(2048 + 3, 0, 0, "R3 C evicts A");
      lookup(1, 0, 1, "R3 A evicts B");
      lookup(2051, 1, 0, "R3 C resident");
   endtask

   task automatic t_prime();
      set_mode(2'd1);
      lookup(1, 0, 0, "R4 A fill");
      lookup(1022, 0, 1, "R4 B same prime set");
      lookup(1 + 64'd1021 * 50000, 0, 0, "R4 C large block evicts A");
      lookup(1, 0, 1, "R4 A evicts B");
      lookup(1 + 64'd1021 * 50000, 1, 0, "R4 C resident");
   endtask

   task automatic t_flush();
      longint pbase;
      int busy_cnt;
      bit ready_seen;
      pbase = longint'(20'h00ABC) << 6;
      lookup(pbase, 0, 0, "R7 fill k0");
      lookup(pbase + 17, 0, 0, "R7 fill k17");
      lookup(pbase + 63, 0, 0, "R7 fill k63");
      lookup(pbase + 64, 0, 0, "R7 fill other page");
      @(negedge clk);
      flush_valid = 1'b1;
      flush_page  = 20'h00ABC;
      @(negedge clk);
      flush_valid = 1'b0;
      busy_cnt = 0;
      ready_seen = 1'b0;
      while (flush_busy && busy_cnt < 200) begin
         if (req_ready) ready_seen = 1'b1;
         busy_cnt++;
         @(negedge clk);
      end
      check(busy_cnt == 64, "R7 walk length", busy_cnt, 64);
      check(!ready_seen, "R7 ready low while busy", ready_seen, 0);
      lookup(pbase + 64, 1, 0, "R7 other page survives");
      lookup(pbase, 0, 0, "R7 k0 removed");
      lookup(pbase + 17, 0, 0, "R7 k17 removed");
      lookup(pbase + 63, 0, 0, "R7 k63 removed");
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         fails++;
         checks++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 50000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_base();
      t_b2b();
      t_xor();
      t_prime();
      t_flush();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule